// File: doc/BRIEF.md
# Linked-List Sort DMA Walker

The walker follows a chain of parameter nodes held in system memory and hands each visited node to a downstream consumer as an address and size descriptor. A start table in memory supplies the entry links of the chains. Each node carries two 32-bit words: the transfer size at byte offset 0x18 and the link to the following node at byte offset 0x1C. Two reserved link values steer the walk. Value 1 ends the walk. Value 2 reads the next entry of the start table.

A walk is launched by writing a 1 to the start bit. Configuration inputs give the table address, the table entry width (16 or 32 bits), the node base address and an option that scales every link by 32. All memory traffic uses a 32-bit read port with one request outstanding at a time. Descriptors leave on a valid/ready channel. A node limit stops a walk that never reaches an end link, and in that case an error flag is raised. Every walk finishes with a one-cycle completion interrupt.

Top module: `sort_list_walker`

## Requirements
- R1: A start write with start_wbit0 = 1 while idle begins a walk, and busy is high on the next cycle. A start write with start_wbit0 = 0 is ignored, and a start write while a walk is busy is ignored.
- R2: Each walk resets the table index to 0. Every table read uses the current index and then adds 1 to it. The entry byte address is cfg_tbl_addr + 4*index when cfg_tbl_wide = 1 and cfg_tbl_addr + 2*index when cfg_tbl_wide = 0.
- R3: With cfg_tbl_wide = 0 the entry is a 16-bit halfword, zero-extended. The memory word is read at the byte address with bits 1:0 cleared. Byte address bit 1 = 0 selects data bits 15:0, and bit 1 = 1 selects bits 31:16.
- R4: When cfg_link_x32 = 1, every link is multiplied by 32 before it is added to the base.
- R5: The node address is (cfg_base + scaled link) modulo 2^AW.
- R6: For each node, the walker reads the next link at node address + 0x1C and the size at node address + 0x18, then emits the descriptor (node address, size).
- R7: A link of 1 ends the walk, and a link of 2 fetches the next table entry. Both values are tested on the raw link before scaling, whether the link came from the table or from a node.
- R8: While desc_valid is high and desc_ready is low, desc_addr and desc_size hold and the walk does not advance.
- R9: At the end of a walk, busy falls and done_irq is high for exactly one cycle on the same edge.
- R10: If a walk reaches a node beyond cfg_node_limit nodes, it emits no descriptor for that node, sets err_runaway and ends as in R9. err_runaway clears on the next accepted start.
- R11: After reset, busy, desc_valid, done_irq, err_runaway and mem_rd_req are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_wr | input | 1 | Write strobe for the start register |
| start_wbit0 | input | 1 | Bit 0 of the written start value |
| cfg_tbl_addr | input | AW | Byte address of the start table |
| cfg_tbl_wide | input | 1 | Table entry width: 1 = 32-bit, 0 = 16-bit |
| cfg_base | input | AW | Base byte address that links are added to |
| cfg_link_x32 | input | 1 | Scale links by 32 |
| cfg_node_limit | input | CW | Maximum number of nodes in one walk |
| mem_rd_req | output | 1 | Read request, one cycle |
| mem_rd_addr | output | AW | Word-aligned byte address of the read |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Returned word |
| desc_valid | output | 1 | Descriptor valid |
| desc_ready | input | 1 | Consumer accepts the descriptor |
| desc_addr | output | AW | Node address |
| desc_size | output | 32 | Node transfer size |
| busy | output | 1 | Walk in progress (status) |
| done_irq | output | 1 | Completion interrupt pulse |
| err_runaway | output | 1 | Walk stopped by the node limit |

## Verification
The assertions assume a consumer that may drop desc_ready at any time. They also assume a memory that answers each request with exactly one mem_rd_valid pulse, and configuration inputs that stay constant during a walk. The bench memory model answers one cycle after each request and never produces an unsolicited valid. The bench changes configuration only between walks. It toggles desc_ready from a pseudo-random bit sequence, so stalls occur at varied points in the descriptor stream.

// File: rtl/slw_pkg.sv
package slw_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_TBL_REQ, ST_TBL_WAIT, ST_DECIDE,
    ST_LNK_REQ, ST_LNK_WAIT, ST_SZ_REQ, ST_SZ_WAIT,
    ST_EMIT, ST_DONE
  } walk_st_t;

  localparam logic [31:0] LINK_STOP   = 32'd1;
  localparam logic [31:0] LINK_RELOAD = 32'd2;
  localparam int          OFS_NEXT    = 28;
  localparam int          OFS_SIZE    = 24;
endpackage

// File: rtl/slw_addr_gen.sv
module slw_addr_gen #(
  parameter int AW = 24,
  parameter int IW = 16
) (
  input  logic [AW-1:0] tbl_addr,
  input  logic [IW-1:0] tbl_idx,
  input  logic          tbl_wide,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] link,
  input  logic          link_x32,
  output logic [AW-1:0] tbl_word_addr,
  output logic          tbl_half_hi,
  output logic [AW-1:0] node_addr
);
  logic [AW-1:0] tbl_byte;
  logic [AW-1:0] link_scaled;

  always_comb begin
    if (tbl_wide) tbl_byte = tbl_addr + AW'({tbl_idx, 2'b00});
    else          tbl_byte = tbl_addr + AW'({tbl_idx, 1'b0});
    tbl_word_addr = tbl_byte & ~AW'(3);
    tbl_half_hi   = tbl_byte[1];
    link_scaled   = link_x32 ? {link[AW-6:0], 5'b00000} : link;
    node_addr     = base + link_scaled;
  end
endmodule

// File: rtl/slw_entry_sel.sv
module slw_entry_sel (
  input  logic [31:0] rd_data,
  input  logic        wide,
  input  logic        half_hi,
  output logic [31:0] entry
);
  always_comb begin
    if (wide)         entry = rd_data;
    else if (half_hi) entry = {16'h0000, rd_data[31:16]};
    else              entry = {16'h0000, rd_data[15:0]};
  end
endmodule

// File: rtl/slw_ctrl.sv
module slw_ctrl
  import slw_pkg::*;
#(
  parameter int AW = 24,
  parameter int IW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_wr,
  input  logic          start_wbit0,
  input  logic [CW-1:0] cfg_node_limit,
  input  logic [AW-1:0] tbl_word_addr,
  input  logic          tbl_half_hi,
  input  logic [AW-1:0] node_addr,
  input  logic [31:0]   tbl_entry,
  output logic [IW-1:0] tbl_idx,
  output logic [31:0]   link_q,
  output logic          half_q,
  output logic          mem_rd_req,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rd_valid,
  input  logic [31:0]   mem_rd_data,
  output logic          desc_valid,
  input  logic          desc_ready,
  output logic [AW-1:0] desc_addr,
  output logic [31:0]   desc_size,
  output logic          busy,
  output logic          done_irq,
  output logic          err_runaway
);
  localparam logic [AW-1:0] NEXT_OFS = AW'(OFS_NEXT);
  localparam logic [AW-1:0] SIZE_OFS = AW'(OFS_SIZE);

  walk_st_t      st;
  logic [AW-1:0] node_q;
  logic [CW-1:0] cnt_q;

  always_comb begin
    mem_rd_req  = (st == ST_TBL_REQ) || (st == ST_LNK_REQ) || (st == ST_SZ_REQ);
    case (st)
      ST_LNK_REQ: mem_rd_addr = node_q + NEXT_OFS;
      ST_SZ_REQ:  mem_rd_addr = node_q + SIZE_OFS;
      default:    mem_rd_addr = tbl_word_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      tbl_idx     <= '0;
      link_q      <= '0;
      half_q      <= 1'b0;
      node_q      <= '0;
      cnt_q       <= '0;
      desc_valid  <= 1'b0;
      desc_addr   <= '0;
      desc_size   <= '0;
      busy        <= 1'b0;
      done_irq    <= 1'b0;
      err_runaway <= 1'b0;
    end else begin
      done_irq <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start_wr && start_wbit0) begin
            tbl_idx     <= '0;
            cnt_q       <= '0;
            err_runaway <= 1'b0;
            busy        <= 1'b1;
            st          <= ST_TBL_REQ;
          end
        end
        ST_TBL_REQ: begin
          half_q  <= tbl_half_hi;
          tbl_idx <= tbl_idx + 1'b1;
          st      <= ST_TBL_WAIT;
        end
        ST_TBL_WAIT: begin
          if (mem_rd_valid) begin
            link_q <= tbl_entry;
            st     <= ST_DECIDE;
          end
        end
        ST_DECIDE: begin
          if (link_q == LINK_STOP) begin
            st <= ST_DONE;
          end else if (link_q == LINK_RELOAD) begin
            st <= ST_TBL_REQ;
          end else if (cnt_q == cfg_node_limit) begin
            err_runaway <= 1'b1;
            st          <= ST_DONE;
          end else begin
            node_q <= node_addr;
            cnt_q  <= cnt_q + 1'b1;
            st     <= ST_LNK_REQ;
          end
        end
        ST_LNK_REQ: st <= ST_LNK_WAIT;
        ST_LNK_WAIT: begin
          if (mem_rd_valid) begin
            link_q <= mem_rd_data;
            st     <= ST_SZ_REQ;
          end
        end
        ST_SZ_REQ: st <= ST_SZ_WAIT;
        ST_SZ_WAIT: begin
          if (mem_rd_valid) begin
            desc_size  <= mem_rd_data;
            desc_addr  <= node_q;
            desc_valid <= 1'b1;
            st         <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (desc_ready) begin
            desc_valid <= 1'b0;
            st         <= ST_DECIDE;
          end
        end
        ST_DONE: begin
          busy     <= 1'b0;
          done_irq <= 1'b1;
          st       <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R8: a stalled descriptor keeps its contents
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    desc_valid && !desc_ready |=> desc_valid && $stable(desc_addr) && $stable(desc_size));

  // R8: no descriptor outside a walk
  p_desc_in_walk_r8: assert property (@(posedge clk) disable iff (rst)
    desc_valid |-> busy);

  // R9: interrupt lasts a single cycle
  p_irq_single_r9: assert property (@(posedge clk) disable iff (rst)
    done_irq |=> !done_irq);

  // R9: busy drops together with the interrupt
  p_irq_with_idle_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done_irq);

  // R1: memory is only read during a walk
  p_req_in_walk_r1: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> busy);
endmodule

// File: rtl/sort_list_walker.sv
module sort_list_walker #(
  parameter int AW = 24,
  parameter int IW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_wr,
  input  logic          start_wbit0,
  input  logic [AW-1:0] cfg_tbl_addr,
  input  logic          cfg_tbl_wide,
  input  logic [AW-1:0] cfg_base,
  input  logic          cfg_link_x32,
  input  logic [CW-1:0] cfg_node_limit,
  output logic          mem_rd_req,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rd_valid,
  input  logic [31:0]   mem_rd_data,
  output logic          desc_valid,
  input  logic          desc_ready,
  output logic [AW-1:0] desc_addr,
  output logic [31:0]   desc_size,
  output logic          busy,
  output logic          done_irq,
  output logic          err_runaway
);
  logic [IW-1:0] tbl_idx;
  logic [31:0]   link_q;
  logic          half_q;
  logic [AW-1:0] tbl_word_addr;
  logic          tbl_half_hi;
  logic [AW-1:0] node_addr;
  logic [31:0]   tbl_entry;

  slw_addr_gen #(.AW(AW), .IW(IW)) u_addr (
    .tbl_addr      (cfg_tbl_addr),
    .tbl_idx       (tbl_idx),
    .tbl_wide      (cfg_tbl_wide),
    .base          (cfg_base),
    .link          (link_q[AW-1:0]),
    .link_x32      (cfg_link_x32),
    .tbl_word_addr (tbl_word_addr),
    .tbl_half_hi   (tbl_half_hi),
    .node_addr     (node_addr)
  );

  slw_entry_sel u_sel (
    .rd_data (mem_rd_data),
    .wide    (cfg_tbl_wide),
    .half_hi (half_q),
    .entry   (tbl_entry)
  );

  slw_ctrl #(.AW(AW), .IW(IW), .CW(CW)) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .start_wr       (start_wr),
    .start_wbit0    (start_wbit0),
    .cfg_node_limit (cfg_node_limit),
    .tbl_word_addr  (tbl_word_addr),
    .tbl_half_hi    (tbl_half_hi),
    .node_addr      (node_addr),
    .tbl_entry      (tbl_entry),
    .tbl_idx        (tbl_idx),
    .link_q         (link_q),
    .half_q         (half_q),
    .mem_rd_req     (mem_rd_req),
    .mem_rd_addr    (mem_rd_addr),
    .mem_rd_valid   (mem_rd_valid),
    .mem_rd_data    (mem_rd_data),
    .desc_valid     (desc_valid),
    .desc_ready     (desc_ready),
    .desc_addr      (desc_addr),
    .desc_size      (desc_size),
    .busy           (busy),
    .done_irq       (done_irq),
    .err_runaway    (err_runaway)
  );
endmodule

// File: tb/test_sort_list_walker.sv
`timescale 1ns/1ps
module test_sort_list_walker;
  localparam int AW = 12;
  localparam int IW = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_wr = 1'b0;
  logic          start_wbit0 = 1'b0;
  logic [AW-1:0] cfg_tbl_addr = '0;
  logic          cfg_tbl_wide = 1'b1;
  logic [AW-1:0] cfg_base = '0;
  logic          cfg_link_x32 = 1'b0;
  logic [CW-1:0] cfg_node_limit = 16'd16;
  logic          mem_rd_req;
  logic [AW-1:0] mem_rd_addr;
  logic          mem_rd_valid = 1'b0;
  logic [31:0]   mem_rd_data = '0;
  logic          desc_valid;
  logic          desc_ready = 1'b0;
  logic [AW-1:0] desc_addr;
  logic [31:0]   desc_size;
  logic          busy;
  logic          done_irq;
  logic          err_runaway;

  int total = 0;
  int bad = 0;
  int seen = 0;
  logic [31:0] mem [0:1023];
  logic [AW-1:0] exp_addr [$];
  logic [31:0]   exp_size [$];

  always #2 clk = ~clk;

  sort_list_walker #(.AW(AW), .IW(IW), .CW(CW)) i_sort_list_walker (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr32(input int ba, input logic [31:0] v);
    mem[ba/4] = v;
  endtask

  task automatic push(input logic [AW-1:0] a, input logic [31:0] s);
    exp_addr.push_back(a);
    exp_size.push_back(s);
  endtask

  task automatic node(input int ba, input logic [31:0] sz, input logic [31:0] nxt);
    wr32(ba + 24, sz);
    wr32(ba + 28, nxt);
  endtask

  task automatic do_start(input logic b0);
    @(posedge clk); #1;
    start_wr = 1'b1; start_wbit0 = b0;
    @(posedge clk); #1;
    start_wr = 1'b0; start_wbit0 = 1'b0;
  endtask

  task automatic finish_walk(input logic exp_err);
    do @(negedge clk); while (!done_irq);
    chk("R9 busy low with irq", {31'd0, busy}, 32'd0);
    chk("R10 error flag", {31'd0, err_runaway}, {31'd0, exp_err});
    @(negedge clk);
    chk("R9 irq single cycle", {31'd0, done_irq}, 32'd0);
    chk("R6 all descriptors consumed", exp_addr.size(), 32'd0);
  endtask

  // memory model: one-cycle latency
  initial begin
    forever begin
      @(negedge clk);
      if (mem_rd_req) begin
        logic [AW-1:0] a;
        a = mem_rd_addr;
        @(posedge clk); #1;
        mem_rd_valid = 1'b1;
        mem_rd_data = mem[a[AW-1:2]];
        @(posedge clk); #1;
        mem_rd_valid = 1'b0;
      end
    end
  end

  // consumer ready pattern
  initial begin
    logic [7:0] lfsr = 8'hA5;
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      desc_ready = lfsr[0] | lfsr[2];
    end
  end

  // scoreboard monitor
  initial begin
    logic stalled = 1'b0;
    logic [AW-1:0] st_a;
    logic [31:0] st_s;
    forever begin
      @(negedge clk);
      if (stalled && desc_valid) begin
        chk("R8 held addr", {20'd0, desc_addr}, {20'd0, st_a});
        chk("R8 held size", desc_size, st_s);
      end
      stalled = 1'b0;
      if (desc_valid && !desc_ready) begin
        stalled = 1'b1; st_a = desc_addr; st_s = desc_size;
      end
      if (desc_valid && desc_ready) begin
        seen++;
        if (exp_addr.size() == 0) begin
          chk("R6 unexpected descriptor", {20'd0, desc_addr}, 32'hFFFFFFFF);
        end else begin
          chk("R5 R6 descriptor addr", {20'd0, desc_addr}, {20'd0, exp_addr.pop_front()});
          chk("R6 descriptor size", desc_size, exp_size.pop_front());
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL R9 watchdog: actual=still running expected=walk done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    // scenario A: 32-bit table, reload and end (R2 R5 R6 R7)
    wr32(12'h100, 32'h40); wr32(12'h104, 32'h80); wr32(12'h108, 32'h1);
    node(12'h440, 32'h111, 32'h100);
    node(12'h500, 32'h222, 32'h2);
    node(12'h480, 32'h333, 32'h2);
    // scenario B: 16-bit table, x32 scaling (R3 R4 R7)
    wr32(12'h200, 32'h0005_0003); wr32(12'h204, 32'hFFFF_0001);
    node(12'h860, 32'hA1, 32'h2);
    node(12'h8A0, 32'hA2, 32'h2);
    // scenario C: address wrap (R5)
    wr32(12'h300, 32'hC0);
    node(12'h040, 32'hC1, 32'h1);
    // scenario D: runaway self loop (R10)
    wr32(12'h320, 32'hA00);
    node(12'hA00, 32'hD1, 32'hA00);

    repeat (3) @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 busy", {31'd0, busy}, 32'd0);
    chk("R11 desc_valid", {31'd0, desc_valid}, 32'd0);
    chk("R11 done_irq", {31'd0, done_irq}, 32'd0);
    chk("R11 err_runaway", {31'd0, err_runaway}, 32'd0);
    chk("R11 mem_rd_req", {31'd0, mem_rd_req}, 32'd0);

    // R1: bit0 clear is ignored
    do_start(1'b0);
    repeat (8) @(negedge clk);
    chk("R1 bit0 clear ignored busy", {31'd0, busy}, 32'd0);
    chk("R1 bit0 clear ignored descriptors", seen, 32'd0);

    // scenario A with a second start during the walk (R1)
    cfg_tbl_addr = 12'h100; cfg_tbl_wide = 1'b1; cfg_base = 12'h400; cfg_link_x32 = 1'b0;
    push(12'h440, 32'h111); push(12'h500, 32'h222); push(12'h480, 32'h333);
    do_start(1'b1);
    @(negedge clk);
    chk("R1 busy after start", {31'd0, busy}, 32'd1);
    repeat (3) @(posedge clk);
    do_start(1'b1);
    finish_walk(1'b0);
    repeat (8) @(negedge clk);
    chk("R1 start while busy ignored", {31'd0, busy}, 32'd0);
    chk("R2 R7 descriptor count A", seen, 32'd3);

    // scenario B (R3 R4 R7 before scaling)
    cfg_tbl_addr = 12'h200; cfg_tbl_wide = 1'b0; cfg_base = 12'h800; cfg_link_x32 = 1'b1;
    push(12'h860, 32'hA1); push(12'h8A0, 32'hA2);
    do_start(1'b1);
    finish_walk(1'b0);
    chk("R3 R4 descriptor count B", seen, 32'd5);

    // scenario D (R10)
    cfg_tbl_addr = 12'h320; cfg_tbl_wide = 1'b1; cfg_base = 12'h000; cfg_link_x32 = 1'b0;
    cfg_node_limit = 16'd4;
    for (int k = 0; k < 4; k++) push(12'hA00, 32'hD1);
    do_start(1'b1);
    finish_walk(1'b1);
    chk("R10 limited descriptors", seen, 32'd9);

    // scenario C (R5 wrap) also clears the error (R10)
    cfg_tbl_addr = 12'h300; cfg_base = 12'hF80; cfg_node_limit = 16'd16;
    push(12'h040, 32'hC1);
    do_start(1'b1);
    @(negedge clk);
    chk("R10 error cleared on start", {31'd0, err_runaway}, 32'd0);
    finish_walk(1'b0);
    chk("R5 descriptor count C", seen, 32'd10);

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule